// File: doc/BRIEF.md
# Mapped 16-to-36-bit DMA Write Packer

This block takes write traffic from a 16-bit bus DMA master and stores it into a memory of 36-bit words. A transfer is started with a bus byte address, a byte count and a choice of byte or 16-bit word mode. The data then arrives on a ready/valid stream, one beat per byte or per word. For every beat the bus address is translated through an external page map. Each map entry holds a valid bit, a read-reverse flag and a physical page base. The beat is then packed into one 18-bit half of the target 36-bit word and written back, either as a whole word or merged with the word's current contents.

Each 36-bit word carries two bus words. The bus word at byte offset 0 sits in the left half (bits 35:18), and the one at offset 2 sits in the right half (bits 17:0). The upper two bits of each half are spare and are written as zero. Within a half, bus byte 0 is the low byte and bus byte 1 is the high byte. A transfer ends in one of two ways. It can run out of bytes, in which case done is raised with a residual of zero. Or it can reach an address that cannot be mapped or that lands outside physical memory. In that case it stops before consuming the beat, raises done with the residual byte count, and sets a timeout flag. The flag stays set until the next transfer starts.

Top module: `dma36_packer`

## Requirements
- R1: In word mode with a non-reverse page, a beat at byte offset 0 (address bit 1 = 0) writes the whole 36-bit word as {2'b00, data, 18'b0}. This clears the right half and all spare bits.
- R2: In word mode with a non-reverse page, a beat at byte offset 2 keeps bits 35:18 and sets bits 17:0 to {2'b00, data}.
- R3: When the page's read-reverse flag is set, a word beat to either half replaces only that half with {2'b00, data} and keeps the other half.
- R4: In byte mode, a beat at byte offset 0 writes the whole word as {10'b0, byte, 18'b0}, whatever the read-reverse flag says.
- R5: In byte mode, offset 1 replaces bits 33:26 and clears bits 35:34; offset 2 replaces bits 7:0; offset 3 replaces bits 15:8 and clears bits 17:16. All other bits are kept. Only the low 8 data bits are used.
- R6: The map index is address bits 16:11 (page number = address bits 17:11). The physical word address is the entry's base plus address bits 10:2. Consecutive beats advance the address by 1 (byte) or 2 (word) and may cross pages.
- R7: A beat whose address has bit 19 or 18 set, or page number 64 or above, or an entry with the valid bit clear, is not consumed and causes no write. The transfer ends with done, the timeout flag set, and the residual equal to the bytes not yet moved.
- R8: A beat whose physical word address (base + offset, computed without wrap) is 3072 or more is handled in the same way as in R7: no write, done, timeout set, and the residual reported.
- R9: A transfer that moves all its bytes raises done for one cycle with residual 0 and timeout clear. A zero count raises done on the cycle after start.
- R10: In word mode the start address and the count are both rounded down to even before use.
- R11: While idle (busy low), in_ready and mem_we stay low. A write happens only on a cycle where in_valid and in_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; accepted only while idle |
| start_addr | input | 20 | Bus byte address of the first beat (bits 19:18 must be zero) |
| start_count | input | 16 | Byte count of the transfer |
| start_byte_mode | input | 1 | 1 = byte beats, 0 = 16-bit word beats |
| in_valid | input | 1 | Stream data valid |
| in_ready | output | 1 | Stream data accepted this cycle |
| in_data | input | 16 | Stream data; the low byte only in byte mode |
| map_idx | output | 6 | Page map index for the current address |
| map_valid | input | 1 | Valid bit of the indexed map entry |
| map_rrev | input | 1 | Read-reverse flag of the indexed map entry |
| map_base | input | 12 | Physical word base of the indexed page |
| mem_addr | output | 12 | Physical word address |
| mem_rdata | input | 36 | Current contents of the addressed word (combinational read) |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 36 | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout | output | 1 | Last transfer stopped on a map or memory fault |
| residual | output | 16 | Bytes not moved by the last transfer |

## Verification
The packer holds only a small amount of state: the current address, the remaining count, the mode and the end status. A wrong address or mode shows up on the next accepted beat as a write to the wrong word or the wrong half. A whole-memory comparison after each transfer catches it. A wrong remaining count shows up when the transfer ends: done comes too early or too late, and the residual and the number of beats taken no longer match. A fault that is detected late, or not at all, leaves an unexpected write in memory, or a timeout flag that disagrees with the expected one, in the same transfer.

// File: rtl/dma36_pkg.sv
package dma36_pkg;
    localparam int BUS_W  = 16;
    localparam int HALF_W = 18;
    localparam int WORD_W = 2 * HALF_W;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MAP  = 2'd1,
        FLT_NXM  = 2'd2
    } fault_e;
endpackage

// File: rtl/dma36_xlate.sv
module dma36_xlate
    import dma36_pkg::*;
#(
    parameter int XA_W      = 20,
    parameter int BA_W      = 18,
    parameter int PG_OFF_W  = 9,
    parameter int MAP_N     = 64,
    parameter int PA_W      = 12,
    parameter int MEM_WORDS = 3072
) (
    input  logic [XA_W-3:0]            word_addr,
    output logic [$clog2(MAP_N)-1:0]   map_idx,
    input  logic                       map_valid,
    input  logic [PA_W-1:0]            map_base,
    output logic [PA_W-1:0]            phys_addr,
    output fault_e                     fault
);
    localparam int IDX_W   = $clog2(MAP_N);
    localparam int VPN_LSB = PG_OFF_W;
    localparam int VPN_W   = BA_W - 2 - PG_OFF_W;

    logic [VPN_W-1:0]    vpn;
    logic [PG_OFF_W-1:0] woff;
    logic [PA_W:0]       sum;
    logic                mbz_hit;
    logic                range_hit;
    logic                nxm_hit;

    generate
        if (XA_W > BA_W) begin : g_mbz
            assign mbz_hit = |word_addr[XA_W-3:BA_W-2];
        end else begin : g_no_mbz
            assign mbz_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        vpn       = word_addr[BA_W-3:VPN_LSB];
        woff      = word_addr[VPN_LSB-1:0];
        map_idx   = vpn[IDX_W-1:0];
        range_hit = (vpn >= VPN_W'(MAP_N));
        sum       = {1'b0, map_base} + (PA_W+1)'(woff);
        phys_addr = sum[PA_W-1:0];
        nxm_hit   = (sum >= (PA_W+1)'(MEM_WORDS));
        if (mbz_hit || range_hit || !map_valid) begin
            fault = FLT_MAP;
        end else if (nxm_hit) begin
            fault = FLT_NXM;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/dma36_merge.sv
module dma36_merge
    import dma36_pkg::*;
(
    input  logic [1:0]        boff,
    input  logic              byte_mode,
    input  logic              rrev,
    input  logic [BUS_W-1:0]  din,
    input  logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] new_word
);
    logic [HALF_W-1:0] old_l, old_r;
    logic [HALF_W-1:0] new_l, new_r;
    logic [HALF_W-1:0] wide;
    logic [BYTE_W-1:0] bval;

    always_comb begin
        old_l = old_word[WORD_W-1:HALF_W];
        old_r = old_word[HALF_W-1:0];
        new_l = old_l;
        new_r = old_r;
        wide  = {2'b00, din};
        bval  = din[BYTE_W-1:0];
        if (!byte_mode) begin
            if (!boff[1]) begin
                new_l = wide;
                if (!rrev) begin
                    new_r = '0;
                end
            end else begin
                new_r = wide;
            end
        end else begin
            unique case (boff)
                2'd0: begin
                    new_l = {{(HALF_W-BYTE_W){1'b0}}, bval};
                    new_r = '0;
                end
                2'd1: new_l = {2'b00, bval, old_l[BYTE_W-1:0]};
                2'd2: new_r = {old_r[HALF_W-1:BYTE_W], bval};
                default: new_r = {2'b00, bval, old_r[BYTE_W-1:0]};
            endcase
        end
        new_word = {new_l, new_r};
    end
endmodule

// File: rtl/dma36_packer.sv
module dma36_packer
    import dma36_pkg::*;
#(
    parameter int XA_W      = 20,
    parameter int BA_W      = 18,
    parameter int PG_OFF_W  = 9,
    parameter int MAP_N     = 64,
    parameter int PA_W      = 12,
    parameter int MEM_WORDS = 3072,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = $clog2(MAP_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XA_W-1:0]   start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              start_byte_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BUS_W-1:0]  in_data,
    output logic [IDX_W-1:0]  map_idx,
    input  logic              map_valid,
    input  logic              map_rrev,
    input  logic [PA_W-1:0]   map_base,
    output logic [PA_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [CNT_W-1:0]  residual
);
    typedef struct packed {
        logic             busy;
        logic             bmode;
        logic [XA_W-1:0]  addr;
        logic [CNT_W-1:0] rem;
        logic             done;
        logic             tmo;
        logic [CNT_W-1:0] resid;
    } state_t;

    state_t           st_d, st_q;
    fault_e           fault;
    logic             fire;
    logic [CNT_W-1:0] cnt_in;
    logic [CNT_W-1:0] step_c;
    logic [XA_W-1:0]  step_a;

    dma36_xlate #(
        .XA_W(XA_W), .BA_W(BA_W), .PG_OFF_W(PG_OFF_W),
        .MAP_N(MAP_N), .PA_W(PA_W), .MEM_WORDS(MEM_WORDS)
    ) u_xlate (
        .word_addr (st_q.addr[XA_W-1:2]),
        .map_idx   (map_idx),
        .map_valid (map_valid),
        .map_base  (map_base),
        .phys_addr (mem_addr),
        .fault     (fault)
    );

    dma36_merge u_merge (
        .boff      (st_q.addr[1:0]),
        .byte_mode (st_q.bmode),
        .rrev      (map_rrev),
        .din       (in_data),
        .old_word  (mem_rdata),
        .new_word  (mem_wdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        fire       = 1'b0;
        step_c     = st_q.bmode ? CNT_W'(1) : CNT_W'(2);
        step_a     = st_q.bmode ? XA_W'(1) : XA_W'(2);
        cnt_in     = start_byte_mode ? start_count
                                     : {start_count[CNT_W-1:1], 1'b0};
        if (!st_q.busy) begin
            if (start) begin
                st_d.bmode = start_byte_mode;
                st_d.addr  = start_byte_mode ? start_addr
                                             : {start_addr[XA_W-1:1], 1'b0};
                st_d.rem   = cnt_in;
                st_d.tmo   = 1'b0;
                if (cnt_in == '0) begin
                    st_d.done  = 1'b1;
                    st_d.resid = '0;
                end else begin
                    st_d.busy  = 1'b1;
                end
            end
        end else if (fault != FLT_NONE) begin
            st_d.busy  = 1'b0;
            st_d.done  = 1'b1;
            st_d.tmo   = 1'b1;
            st_d.resid = st_q.rem;
        end else if (in_valid) begin
            fire      = 1'b1;
            st_d.addr = st_q.addr + step_a;
            if (st_q.rem <= step_c) begin
                st_d.rem   = '0;
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.resid = '0;
            end else begin
                st_d.rem   = st_q.rem - step_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = st_q.busy && (fault == FLT_NONE);
    assign mem_we   = fire;
    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign timeout  = st_q.tmo;
    assign residual = st_q.resid;
endmodule

// File: rtl/dma36_packer_chk.sv
module dma36_packer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_valid,
    input logic             in_ready,
    input logic             mem_we,
    input logic             busy,
    input logic             done,
    input logic             timeout,
    input logic [CNT_W-1:0] residual
);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!in_ready && !mem_we));

    assert_write_on_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_valid && in_ready));

    assert_clean_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !timeout) |-> (residual == '0));

    assert_fault_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (done && !busy));

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !start) |=> timeout);
endmodule

bind dma36_packer dma36_packer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .mem_we   (mem_we),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .residual (residual)
);

// File: tb/sim_dma36_packer.sv
`timescale 1ns/1ps
module sim_dma36_packer;
    localparam int MEM_WORDS = 3072;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [19:0] start_addr = '0;
    logic [15:0] start_count = '0;
    logic        start_byte_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic [5:0]  map_idx;
    logic        map_valid, map_rrev;
    logic [11:0] map_base;
    logic [11:0] mem_addr;
    logic [35:0] mem_rdata;
    logic        mem_we;
    logic [35:0] mem_wdata;
    logic        busy, done, timeout;
    logic [15:0] residual;

    logic [35:0] mem  [0:4095];
    logic [35:0] refm [0:4095];
    logic        map_v [0:63];
    logic        map_r [0:63];
    logic [11:0] map_b [0:63];
    logic [15:0] dat  [0:255];

    int errors = 0;
    int checks = 0;
    int exp_beats, exp_res, last_beats;

    always #2.5 clk = ~clk;

    assign map_valid = map_v[map_idx];
    assign map_rrev  = map_r[map_idx];
    assign map_base  = map_b[map_idx];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    dma36_packer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_count(start_count), .start_byte_mode(start_byte_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .map_idx(map_idx), .map_valid(map_valid), .map_rrev(map_rrev),
        .map_base(map_base), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .timeout(timeout), .residual(residual)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] pack_ref(input logic [35:0] old, input logic [1:0] off,
                                             input logic [15:0] d, input bit bm, input bit rr);
        if (!bm) begin
            if (off[1])  return {old[35:18], 2'b00, d};
            if (rr)      return {2'b00, d, old[17:0]};
            return {2'b00, d, 18'h0};
        end
        case (off)
            2'd0:    return {10'h0, d[7:0], 18'h0};
            2'd1:    return {2'b00, d[7:0], old[25:0]};
            2'd2:    return {old[35:8], d[7:0]};
            default: return {old[35:18], 2'b00, d[7:0], old[7:0]};
        endcase
    endfunction

    function automatic logic [19:0] ba(input int page, input int w, input int b);
        return 20'((page << 11) | (w << 2) | b);
    endfunction

    task automatic poke(input int idx, input logic [35:0] v);
        mem[idx]  = v;
        refm[idx] = v;
    endtask

    task automatic xfer(input logic [19:0] a0, input int cnt, input bit bm,
                        input bit stall, input string tag);
        logic [19:0] a;
        logic [6:0]  vpn;
        logic [12:0] ph;
        int c, beat, cyc, bad;
        bit e_tmo, fire;
        for (int k = 0; k < 256; k++) dat[k] = 16'($urandom);
        a = bm ? a0 : {a0[19:1], 1'b0};
        c = bm ? cnt : (cnt & ~1);
        beat = 0;
        e_tmo = 0;
        while (c > 0) begin
            vpn = a[17:11];
            ph  = 13'(map_b[vpn[5:0]]) + 13'(a[10:2]);
            if (a[19:18] != 2'b00 || vpn >= 7'd64 || !map_v[vpn[5:0]] ||
                ph >= 13'(MEM_WORDS)) begin
                e_tmo = 1;
                break;
            end
            refm[ph[11:0]] = pack_ref(refm[ph[11:0]], a[1:0], dat[beat], bm, map_r[vpn[5:0]]);
            a = a + (bm ? 20'd1 : 20'd2);
            c = c - (bm ? 1 : 2);
            beat++;
        end
        exp_beats = beat;
        exp_res   = c;
        @(negedge clk);
        start = 1'b1; start_addr = a0; start_count = 16'(cnt); start_byte_mode = bm;
        @(negedge clk);
        start = 1'b0;
        beat = 0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            in_valid = stall ? (($urandom % 4) != 0) : 1'b1;
            in_data  = dat[beat & 255];
            fire = in_valid && in_ready;
            @(negedge clk);
            if (fire) beat++;
            cyc++;
        end
        in_valid = 1'b0;
        last_beats = beat;
        chk(tag, "done seen", 64'(done), 64'(1));
        chk(tag, "residual", 64'(residual), 64'(exp_res));
        chk(tag, "timeout flag", 64'(timeout), 64'(e_tmo));
        chk(tag, "beats taken", 64'(beat), 64'(exp_beats));
        bad = 0;
        for (int k = 0; k < 4096; k++) if (mem[k] !== refm[k]) bad++;
        chk(tag, "memory words differing", 64'(bad), 64'(0));
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) begin
            map_v[i] = (i < 48) && (i % 8 != 5);
            map_r[i] = (i % 4 == 3);
            map_b[i] = 12'((i % 6) * 512 + i * 3);
        end
        map_b[9] = 12'd3000;
        for (int k = 0; k < 4096; k++) poke(k, 36'($urandom) ^ (36'($urandom) << 20));

        repeat (3) @(negedge clk);
        // R11 / R9: reset state
        chk("R11", "busy after reset", 64'(busy), 64'(0));
        chk("R11", "in_ready after reset", 64'(in_ready), 64'(0));
        chk("R11", "mem_we after reset", 64'(mem_we), 64'(0));
        chk("R9", "done after reset", 64'(done), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R1: even half, normal page
        poke(10, 36'hF_FFFF_FFFF);
        xfer(ba(0, 10, 0), 2, 0, 0, "R1");
        chk("R1", "left-half full write", 64'(mem[10]), 64'({2'b00, 16'hA5C3, 18'h0} & 36'h0) | 64'(pack_ref(36'hF_FFFF_FFFF, 2'd0, dat[0], 0, 0)));
        chk("R1", "spare and right bits cleared", 64'(mem[10] & 36'hC_0003_FFFF), 64'(0));
        // R2: odd half keeps left
        xfer(ba(0, 10, 2), 2, 0, 0, "R2");
        chk("R2", "right half merged", 64'(mem[10]), 64'({mem[10][35:18], 2'b00, dat[0]}));
        // R3: read-reverse page 3 (base 1545), word 4 -> 1549
        poke(1549, 36'hF_FFFF_FFFF);
        xfer(ba(3, 4, 0), 2, 0, 0, "R3");
        chk("R3", "left write keeps right", 64'(mem[1549]), 64'({2'b00, dat[0], 18'h3FFFF}));
        xfer(ba(3, 4, 2), 2, 0, 1, "R3");
        chk("R3", "right write keeps left", 64'(mem[1549][17:0]), 64'({2'b00, dat[0]}));
        // R4: byte offset 0 full write
        poke(20, 36'hF_FFFF_FFFF);
        xfer(ba(0, 20, 0), 1, 1, 0, "R4");
        chk("R4", "byte 0 full write", 64'(mem[20]), 64'({10'h0, dat[0][7:0], 18'h0}));
        // R4 on read-reverse page also clears the word
        poke(1550, 36'hF_FFFF_FFFF);
        xfer(ba(3, 5, 0), 1, 1, 0, "R4");
        chk("R4", "byte 0 on reverse page", 64'(mem[1550]), 64'({10'h0, dat[0][7:0], 18'h0}));
        // R5: bytes 1..3 merge
        poke(21, 36'hF_FFFF_FFFF);
        xfer(ba(0, 21, 1), 3, 1, 1, "R5");
        chk("R5", "bytes 1-3 merged", 64'(mem[21]),
            64'({2'b00, dat[0][7:0], 8'hFF, 2'b00, dat[2][7:0], dat[1][7:0]}));
        // R6: translation, page 12 base 36, word 100 -> 136
        xfer(ba(12, 100, 0), 4, 0, 0, "R6");
        chk("R6", "translated word", 64'(mem[136]), 64'({2'b00, dat[0], 2'b00, dat[1]}));
        xfer(ba(1, 510, 0), 16, 0, 1, "R6");
        // R7: invalid entry, out-of-range page, must-be-zero bits, mid-transfer fault
        xfer(ba(5, 3, 0), 6, 0, 0, "R7");
        chk("R7", "no data taken on invalid entry", 64'(last_beats), 64'(0));
        chk("R11", "in_ready low after fault", 64'(in_ready), 64'(0));
        xfer(ba(64, 0, 0), 4, 1, 0, "R7");
        xfer(ba(0, 40, 0) | 20'h80000, 4, 0, 0, "R7");
        xfer(ba(4, 511, 0), 8, 0, 0, "R7");
        chk("R7", "residual after page fault", 64'(residual), 64'(4));
        // R8: nonexistent memory at word 3072
        xfer(ba(9, 71, 0), 8, 0, 0, "R8");
        chk("R8", "residual at memory end", 64'(residual), 64'(4));
        // R9: zero count and clean finish after a fault
        xfer(ba(0, 50, 0), 0, 0, 0, "R9");
        xfer(ba(0, 51, 0), 4, 1, 0, "R9");
        chk("R9", "timeout cleared by new transfer", 64'(timeout), 64'(0));
        // R10: odd address and count in word mode
        xfer(ba(0, 30, 1), 5, 0, 0, "R10");
        chk("R10", "aligned beat count", 64'(last_beats), 64'(2));

        // random mix
        for (int n = 0; n < 60; n++) begin
            int pg;
            pg = ($urandom % 8 == 0) ? int'(64 + $urandom % 64) : int'($urandom % 64);
            xfer(ba(pg, int'($urandom % 512), int'($urandom % 4)),
                 int'($urandom % 49), bit'($urandom % 2), bit'($urandom % 2), "R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule